// File: doc/BRIEF.md
# Trigger Busy Veto Controller

This block sits between the trigger logic of a detector and the read-out sequencer. It forwards a raw physics trigger only while the acquisition is idle. Any trigger that comes while the acquisition is busy is discarded and counted. Every trigger that gets through sets the busy level again. Busy is set at power-up, and only an explicit release command from the host clears it.

After each accepted trigger, the block holds back acknowledges to the storage side's read commands for a fixed compression window. Commands that arrive in that window are queued, and each one is answered once the window closes. The block also watches the flow of stored data words for the current event. A programmable quiet gap after the last word raises a data-timeout flag, which tells the host the event is complete. If completion is not reached within a programmable event limit, an event-timeout flag is raised instead. Both flags stay set until the host clears them with a write-one-to-clear input.

Top module: `trig_veto_ctrl`

## Requirements
- R1: Once reset is released, the outputs are as follows: `busy` is 1, `trig_out` is 0, `cmd_ack` is 0, `veto_count` is 0, and both timeout flags are 0.
- R2: A rising edge on `trig_raw` while `busy` is 0 produces a one-cycle `trig_out` pulse on the third clock edge after the input changes. `busy` goes to 1 on that same edge.
- R3: A rising edge on `trig_raw` while `busy` is 1 produces no `trig_out` pulse and adds one to `veto_count`.
- R4: A one-cycle `release_cmd` clears `busy` on the next edge. It has no effect when `busy` is already 0. If `release_cmd` coincides with a trigger edge that is being vetoed, the trigger stays vetoed.
- R5: A `trig_raw` held high gives exactly one event. Releasing busy while it is still high delivers nothing more.
- R6: After an accepted trigger, `cmd_ack` stays 0 for `HOLD_CYCLES` cycles. The window restarts on every accepted trigger.
- R7: Every `cmd_stb` pulse that arrives during the window is queued. After the window, each one is answered by its own one-cycle `cmd_ack` pulse, and `cmd_ack` is never high on two cycles in a row.
- R8: When no window is running, a `cmd_stb` pulse is acknowledged on the second clock edge after it is sampled.
- R9: After an accepted trigger, once at least one `store_beat` has been seen, `dat_tmo_lim` cycles without a beat set `dat_tmo_irq`. This is the completion flag.
- R10: If an accepted trigger reaches neither completion nor a new trigger within `evt_tmo_lim` cycles, `evt_tmo_irq` is set. Only one of the two flags is set per event.
- R11: Both flags are sticky. `irq_clr` bit 0 clears `evt_tmo_irq`, bit 1 clears `dat_tmo_irq`, and each bit touches only its own flag.
- R12: `veto_count` stops at all ones of its width (16 bits by default). `vcnt_clr` sets it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_raw | input | 1 | Raw trigger, asynchronous level |
| release_cmd | input | 1 | One-cycle command that clears busy |
| cmd_stb | input | 1 | Read command strobe from the storage side |
| store_beat | input | 1 | Pulse per stored data word of the current event |
| evt_tmo_lim | input | TMO_W (24) | Event timeout, in cycles |
| dat_tmo_lim | input | TMO_W (24) | Quiet gap that marks completion, in cycles |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 event flag, bit 1 data flag |
| vcnt_clr | input | 1 | Clears the veto counter |
| trig_out | output | 1 | Delivered trigger pulse |
| busy | output | 1 | Acquisition busy level |
| cmd_ack | output | 1 | Command acknowledge pulse |
| veto_count | output | VCNT_W (16) | Saturating count of vetoed triggers |
| evt_tmo_irq | output | 1 | Event timeout flag |
| dat_tmo_irq | output | 1 | Data timeout (completion) flag |

## Verification
The bench goes after five corner cases.

- A release that lands on the same edge as a trigger that is being vetoed: a design that gives release priority would let a trigger through while the host still thinks the system is busy.
- A trigger held high across a release: a design that gates on the level instead of the edge would deliver a second event.
- Strobes queued inside the compression window: a design that drops them, or that merges back-to-back answers into one long level, would leave read commands hanging.
- The veto counter at its top value: a design without saturation would wrap to zero.
- Each clear bit on its own: a design that clears both flags together would lose a pending completion.

// File: rtl/tvc_pkg.sv
package tvc_pkg;
  localparam int IRQ_EVT = 0;
  localparam int IRQ_DAT = 1;
  localparam int IRQ_N   = 2;
endpackage

// File: rtl/tvc_edge_sync.sv
// Synchronizes an asynchronous level and flags its rising edge for one cycle.
module tvc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R5: an edge is reported for exactly one cycle
  p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tvc_ack_pacer.sv
// Holds read acknowledges back for a window after each accepted trigger,
// queues strobes meanwhile and answers them one pulse at a time.
module tvc_ack_pacer #(
  parameter int HOLD_CYCLES = 175000,
  parameter int PEND_W      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cmd_stb,
  output logic ack
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYCLES);

  logic [HW-1:0]     hold_q, hold_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              ack_q, ack_d;
  logic              in_hold, issue, take;

  always_comb begin
    in_hold = (hold_q != '0);
    issue   = !in_hold && !start && (pend_q != '0) && !ack_q;
    take    = cmd_stb && (pend_q != '1);

    hold_d = hold_q;
    if (start)        hold_d = HOLD_LOAD;
    else if (in_hold) hold_d = hold_q - 1'b1;

    pend_d = pend_q;
    if (take && !issue)      pend_d = pend_q + 1'b1;
    else if (!take && issue) pend_d = pend_q - 1'b1;

    ack_d = issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend_q <= '0;
      ack_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      pend_q <= pend_d;
      ack_q  <= ack_d;
    end
  end

  assign ack = ack_q;

  // R7: answers are single-cycle pulses, never merged
  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  // R6: no answer is visible while the window runs
  p_ack_outside_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> !in_hold);
  // R6: an accepted trigger opens the window
  p_start_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> in_hold);
endmodule

// File: rtl/tvc_timeouts.sv
// Event and data timeout timers with sticky, write-one-to-clear flags.
module tvc_timeouts
  import tvc_pkg::*;
#(
  parameter int TW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             beat,
  input  logic [TW-1:0]    evt_lim,
  input  logic [TW-1:0]    dat_lim,
  input  logic [IRQ_N-1:0] clr,
  output logic [IRQ_N-1:0] flags
);
  logic             run_q, run_d, seen_q, seen_d;
  logic [TW-1:0]    el_q, el_d, qt_q, qt_d;
  logic [IRQ_N-1:0] flag_q, flag_d, set;
  logic             dat_fire, evt_fire;

  always_comb begin
    dat_fire = run_q && seen_q && !beat && (qt_q >= dat_lim);
    evt_fire = run_q && !dat_fire && (el_q >= evt_lim);

    run_d  = run_q;
    seen_d = seen_q;
    el_d   = el_q;
    qt_d   = qt_q;
    if (start) begin
      run_d  = 1'b1;
      seen_d = 1'b0;
      el_d   = '0;
      qt_d   = '0;
    end else if (run_q) begin
      if (dat_fire || evt_fire) run_d = 1'b0;
      if (el_q != '1) el_d = el_q + 1'b1;
      if (beat) begin
        seen_d = 1'b1;
        qt_d   = '0;
      end else if (seen_q && (qt_q != '1)) begin
        qt_d = qt_q + 1'b1;
      end
    end

    set          = '0;
    set[IRQ_EVT] = evt_fire;
    set[IRQ_DAT] = dat_fire;
    flag_d       = set | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      seen_q <= 1'b0;
      el_q   <= '0;
      qt_q   <= '0;
      flag_q <= '0;
    end else begin
      run_q  <= run_d;
      seen_q <= seen_d;
      el_q   <= el_d;
      qt_q   <= qt_d;
      flag_q <= flag_d;
    end
  end

  assign flags = flag_q;

  // R10: an event ends in one outcome only
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(flag_q[IRQ_EVT]) && $rose(flag_q[IRQ_DAT])));

  for (genvar i = 0; i < IRQ_N; i++) begin : g_sticky
    // R11: a flag only falls through its own clear bit
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr[i]) |=> flag_q[i]);
  end
endmodule

// File: rtl/tvc_veto_counter.sv
// Saturating counter of vetoed triggers.
module tvc_veto_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                       cnt_d = '0;
    else if (inc && cnt_q != '1)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R12: the top value is held
  p_no_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && !clr) |=> cnt_q == '1);
endmodule

// File: rtl/trig_veto_ctrl.sv
module trig_veto_ctrl
  import tvc_pkg::*;
#(
  parameter int HOLD_CYCLES = 175000,
  parameter int TMO_W       = 24,
  parameter int VCNT_W      = 16,
  parameter int PEND_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_raw,
  input  logic              release_cmd,
  input  logic              cmd_stb,
  input  logic              store_beat,
  input  logic [TMO_W-1:0]  evt_tmo_lim,
  input  logic [TMO_W-1:0]  dat_tmo_lim,
  input  logic [IRQ_N-1:0]  irq_clr,
  input  logic              vcnt_clr,
  output logic              trig_out,
  output logic              busy,
  output logic              cmd_ack,
  output logic [VCNT_W-1:0] veto_count,
  output logic              evt_tmo_irq,
  output logic              dat_tmo_irq
);
  logic [1:0]       rs_q;
  logic             rst_n_s;
  logic             rise, accept, veto;
  logic             busy_q, busy_d, trig_q, trig_d;
  logic [IRQ_N-1:0] flags;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  tvc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .din(trig_raw), .rise(rise)
  );

  always_comb begin
    accept = rise && !busy_q;
    veto   = rise && busy_q;
    busy_d = busy_q;
    if (accept)           busy_d = 1'b1;
    else if (release_cmd) busy_d = 1'b0;
    trig_d = accept;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b1;
      trig_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      trig_q <= trig_d;
    end
  end

  tvc_ack_pacer #(.HOLD_CYCLES(HOLD_CYCLES), .PEND_W(PEND_W)) u_pacer (
    .clk(clk), .rst_n(rst_n_s), .start(accept), .cmd_stb(cmd_stb), .ack(cmd_ack)
  );

  tvc_timeouts #(.TW(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n_s), .start(accept), .beat(store_beat),
    .evt_lim(evt_tmo_lim), .dat_lim(dat_tmo_lim), .clr(irq_clr), .flags(flags)
  );

  tvc_veto_counter #(.W(VCNT_W)) u_vcnt (
    .clk(clk), .rst_n(rst_n_s), .inc(veto), .clr(vcnt_clr), .cnt(veto_count)
  );

  assign trig_out    = trig_q;
  assign busy        = busy_q;
  assign evt_tmo_irq = flags[IRQ_EVT];
  assign dat_tmo_irq = flags[IRQ_DAT];

  // R3: a delivered trigger was sampled while idle
  p_trig_needs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    trig_q |-> !$past(busy_q));
  // R2: delivery sets busy on the same edge
  p_busy_with_trig_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    trig_q |-> busy_q);
  // R4: a release with no trigger edge leaves the block idle
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (release_cmd && !rise) |=> !busy_q);
endmodule

// File: tb/trig_veto_ctrl_test.sv
`timescale 1ns/1ps
module trig_veto_ctrl_test;
  localparam int H    = 20;
  localparam int TW   = 16;
  localparam int VW   = 4;
  localparam int EVT  = 60;
  localparam int DAT  = 8;
  // table entries: {release first, expect delivery}
  localparam logic [1:0] PLAN [0:7] = '{2'b00, 2'b11, 2'b00, 2'b00,
                                        2'b11, 2'b11, 2'b00, 2'b11};

  logic clk = 1'b0;
  logic rst_n, trig_raw, release_cmd, cmd_stb, store_beat, vcnt_clr;
  logic [TW-1:0] evt_lim, dat_lim;
  logic [1:0] irq_clr;
  logic trig_out, busy, cmd_ack, evt_irq, dat_irq;
  logic [VW-1:0] veto_count;
  int checks = 0, errors = 0, ack_seen = 0, trig_seen = 0;

  always #2 clk = ~clk;

  trig_veto_ctrl #(.HOLD_CYCLES(H), .TMO_W(TW), .VCNT_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .trig_raw(trig_raw), .release_cmd(release_cmd),
    .cmd_stb(cmd_stb), .store_beat(store_beat), .evt_tmo_lim(evt_lim),
    .dat_tmo_lim(dat_lim), .irq_clr(irq_clr), .vcnt_clr(vcnt_clr),
    .trig_out(trig_out), .busy(busy), .cmd_ack(cmd_ack), .veto_count(veto_count),
    .evt_tmo_irq(evt_irq), .dat_tmo_irq(dat_irq)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (cmd_ack)  ack_seen++;
      if (trig_out) trig_seen++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_release();
    release_cmd = 1'b1; cyc(1); release_cmd = 1'b0;
  endtask

  // leaves the caller at the negedge after the delivery edge
  task automatic fire(output logic got);
    trig_raw = 1'b1;
    cyc(3);
    got = trig_out;
    trig_raw = 1'b0;
  endtask

  task automatic pulse_clr(input logic [1:0] bits);
    irq_clr = bits; cyc(1); irq_clr = 2'b00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic got;
    int vexp, base;
    rst_n = 1'b0; trig_raw = 1'b0; release_cmd = 1'b0; cmd_stb = 1'b0;
    store_beat = 1'b0; vcnt_clr = 1'b0; irq_clr = 2'b00;
    evt_lim = TW'(EVT); dat_lim = TW'(DAT);
    cyc(3); rst_n = 1'b1; cyc(5);

    chk(busy == 1'b1, "R1 busy after reset", busy, 1);
    chk(trig_out == 1'b0 && cmd_ack == 1'b0, "R1 pulses idle", trig_out, 0);
    chk(veto_count == 0, "R1 veto count", veto_count, 0);
    chk(!evt_irq && !dat_irq, "R1 flags", {evt_irq, dat_irq}, 0);

    // R2/R3 table walk
    vexp = 0;
    for (int i = 0; i < 8; i++) begin
      if (PLAN[i][1]) begin
        do_release();
        chk(busy == 1'b0, "R4 release clears busy", busy, 0);
      end
      fire(got);
      if (!PLAN[i][0]) vexp++;
      chk(got == PLAN[i][0], PLAN[i][0] ? "R2 trigger delivered" : "R3 trigger vetoed",
          got, PLAN[i][0]);
      chk(busy == 1'b1, "R2 busy set", busy, 1);
      chk(veto_count == VW'(vexp), "R3 veto count", veto_count, vexp);
      cyc(1);
      chk(trig_out == 1'b0, "R2 single pulse", trig_out, 0);
      cyc(2);
    end
    cyc(H + 5);

    // R6/R7: strobes queued in the window
    base = ack_seen;
    do_release();
    fire(got);
    chk(got == 1'b1, "R6 trigger opens window", got, 1);
    for (int k = 0; k < 3; k++) begin
      cmd_stb = 1'b1; cyc(1); cmd_stb = 1'b0; cyc(1);
    end
    cyc(10);
    chk(ack_seen == base, "R6 ack held in window", ack_seen - base, 0);
    cyc(20);
    chk(ack_seen == base + 3, "R7 one ack per queued strobe", ack_seen - base, 3);

    // R8: strobe with no window
    cmd_stb = 1'b1; cyc(1); cmd_stb = 1'b0;
    chk(cmd_ack == 1'b0, "R8 ack not yet", cmd_ack, 0);
    cyc(1);
    chk(cmd_ack == 1'b1, "R8 ack second edge", cmd_ack, 1);
    cyc(1);
    chk(cmd_ack == 1'b0, "R7 ack one cycle", cmd_ack, 0);

    // R9: completion by quiet gap
    pulse_clr(2'b11);
    cyc(2);
    do_release();
    fire(got);
    for (int k = 0; k < 3; k++) begin
      store_beat = 1'b1; cyc(1); store_beat = 1'b0; cyc(1);
    end
    cyc(DAT - 3);
    chk(dat_irq == 1'b0, "R9 data flag early", dat_irq, 0);
    cyc(4);
    chk(dat_irq == 1'b1, "R9 data flag set", dat_irq, 1);
    cyc(EVT + 5);
    chk(evt_irq == 1'b0, "R10 no event flag after completion", evt_irq, 0);
    pulse_clr(2'b10);
    chk(dat_irq == 1'b0, "R11 data flag cleared", dat_irq, 0);

    // R10: event timeout with no data
    cyc(H);
    do_release();
    fire(got);
    cyc(EVT - 6);
    chk(evt_irq == 1'b0, "R10 event flag early", evt_irq, 0);
    cyc(10);
    chk(evt_irq == 1'b1, "R10 event flag set", evt_irq, 1);
    chk(dat_irq == 1'b0, "R10 data flag stays clear", dat_irq, 0);
    cyc(10);
    chk(evt_irq == 1'b1, "R11 event flag sticky", evt_irq, 1);
    pulse_clr(2'b10);
    chk(evt_irq == 1'b1, "R11 other clear bit ignored", evt_irq, 1);
    pulse_clr(2'b01);
    chk(evt_irq == 1'b0, "R11 event flag cleared", evt_irq, 0);

    // R12: saturation and clear (busy is high here)
    vcnt_clr = 1'b1; cyc(1); vcnt_clr = 1'b0;
    chk(veto_count == 0, "R12 clear", veto_count, 0);
    for (int k = 0; k < 20; k++) begin
      fire(got); cyc(2);
    end
    chk(veto_count == '1, "R12 saturates", veto_count, (1 << VW) - 1);
    vcnt_clr = 1'b1; cyc(1); vcnt_clr = 1'b0;
    chk(veto_count == 0, "R12 clear after saturation", veto_count, 0);

    // R5: held trigger gives one event
    base = trig_seen;
    do_release();
    trig_raw = 1'b1;
    cyc(12);
    chk(trig_seen == base + 1, "R5 one event for held level", trig_seen - base, 1);
    do_release();
    cyc(5);
    chk(trig_seen == base + 1, "R5 no event after release while high", trig_seen - base, 1);
    chk(busy == 1'b0, "R4 busy low after release", busy, 0);
    trig_raw = 1'b0;
    cyc(3);

    // R4: release while idle has no effect
    base = trig_seen;
    do_release();
    cyc(2);
    chk(busy == 1'b0 && trig_seen == base, "R4 idle release no effect", busy, 0);
    chk(veto_count == 0, "R4 idle release leaves count", veto_count, 0);
    fire(got);
    chk(got == 1'b1, "R4 trigger after idle release", got, 1);
    cyc(3);

    // R4: release on the edge of a vetoed trigger
    trig_raw = 1'b1;
    cyc(2);
    release_cmd = 1'b1;
    cyc(1);
    release_cmd = 1'b0;
    chk(trig_out == 1'b0, "R4 coincident trigger vetoed", trig_out, 0);
    chk(busy == 1'b0, "R4 coincident release clears busy", busy, 0);
    chk(veto_count == 1, "R3 coincident veto counted", veto_count, 1);
    trig_raw = 1'b0;
    cyc(3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule